// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus placed in front of a byte-wide non-volatile store with a 13-bit word address space (0000h to 1FFFh). It runs on a fast system clock and oversamples the bus clock and data lines through synchronisers. From these samples it finds Start and Stop conditions and clocks bits in and out on the bus clock edges. The data line is open-drain, so the block only produces an output enable: when the enable is high, the pad pulls the line low. The block never drives the bus clock.

A transaction opens with a device byte that carries a fixed 4-bit type code, a 3-bit chip address and a direction bit. The chip address is compared with three strap inputs, so up to eight of these slaves can share a bus. A write transaction then sends two word-address bytes and any number of data bytes. A read transaction streams bytes from the current pointer. A lock input refuses writes into the top quarter of the address space and has no effect on reads.

The `STORE_W` parameter sets how many low address bits select a physical byte. Setting it equal to `ADDR_W` backs the full 8192-byte space. A smaller value keeps the elaborated array small, and the upper address bits then alias onto the same bytes.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the block is idle and its data-line output enable is low, so the line floats high.
- R2: A falling data line while the bus clock is high (Start) restarts device-byte decoding from any state, including partway through a byte. A rising data line while the bus clock is high (Stop) returns the block to idle with the output enable low. A partly received data byte is never stored.
- R3: The block changes its data-line output enable only while the bus clock is low, except for the release that follows a Stop.
- R4: The device byte is bits [7:4] = 1010b, bits [3:1] = chip address, bit [0] = direction (1 = read), sent MSB first. The block acknowledges by pulling the line low during the ninth clock only when both fields match. Otherwise it does not acknowledge and ignores the bus until the next Start.
- R5: In a write, the device byte is followed by two word-address bytes, high byte first. The pointer becomes the low 13 bits of the high/low pair, and bits [7:5] of the high byte are ignored. Each address byte is acknowledged.
- R6: Every data byte received in a write is acknowledged and stored at the pointer, and the pointer then increments.
- R7: While the lock input is high, write data aimed at 1800h to 1FFFh is discarded. It is still acknowledged and the pointer still increments. While the lock is low, writes to any address are stored.
- R8: Reads return the stored data at every address whatever the state of the lock input.
- R9: In a read, the byte at the pointer is sent MSB first and the pointer increments after each byte, wrapping from 1FFFh to 0000h. Writes wrap in the same way.
- R10: A master not-acknowledge after a read byte ends the read. The block returns to idle and leaves the line released on subsequent clocks.
- R11: A repeated Start keeps the pointer loaded by an earlier write, so a dummy write followed by a read gives a random read. A read without a preceding address also starts at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull the data line low when high |
| strap_addr | input | 3 | Chip address straps compared with device byte bits [3:1] |
| lock_top | input | 1 | Refuse writes to the top quarter of the address space |

## Verification
The checker watches on every cycle the properties that hold in any bus state. It checks that the output enable holds still while the bus clock stays high. It checks that a Stop leaves the block idle and released, and that a Start always reaches device decoding. It also checks that the block never pulls the line while idle or ignoring the bus, that no store commit lands in the locked quarter while the lock is high, and that each pointer step adds exactly one modulo the address space. Only the bench's bus scenarios can show the data itself. These cover the acknowledge pattern over every chip-address value and a wrong type code, the masking of the high address bits, and read-back after sequential writes. They also cover the wrap at the top of the space, the blocked-but-counted locked writes, the pointer surviving a repeated Start, and the silence after a master not-acknowledge.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned STRAP_W = 3;
  localparam logic [3:0]  DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD,
    ST_SKIP
  } eep_state_e;

endpackage

// File: rtl/eep_rst_sync.sv
module eep_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic         scl_q, sda_q;

  // Bus idles high, so the synchronisers reset to one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      scl_q  <= scl_sh[MSB];
      sda_q  <= sda_sh[MSB];
    end
  end

  assign scl_lvl  = scl_sh[MSB];
  assign sda_lvl  = sda_sh[MSB];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  // Data edges with the clock held high on both samples are bus conditions.
  assign start_p  = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_p   = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned STORE_W = 11,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              lock,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              commit
);

  localparam int unsigned DEPTH = 1 << STORE_W;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [STORE_W-1:0] idx;
  logic               in_top;

  assign idx    = STORE_W'(addr);
  // Top quarter: the two most significant address bits both set.
  assign in_top = &addr[ADDR_W-1 -: 2];
  assign commit = we & ~(lock & in_top);

  always_ff @(posedge clk) begin
    if (commit) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/eep_slave_ctrl.sv
module eep_slave_ctrl
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_p,
  input  logic               stop_p,
  input  logic               sda_lvl,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rdata,
  output logic               sda_oe,
  output logic               mem_we,
  output logic [BYTE_W-1:0]  mem_wdata,
  output logic [ADDR_W-1:0]  ptr,
  output logic               ptr_step,
  output eep_state_e         state
);

  eep_state_e        st, st_n;
  logic [3:0]        cnt, cnt_n;
  logic [BYTE_W-1:0] rx, rx_n, tx, tx_n, hi, hi_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n, ptr_inc;
  logic              oe, oe_n, mack, mack_n;
  logic              active, rx_state, dev_hit;
  logic [2*BYTE_W-1:0] word_addr;

  assign active    = (st != ST_IDLE) && (st != ST_SKIP);
  assign rx_state  = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WR);
  assign dev_hit   = (rx[7:4] == DEV_TYPE) && (rx[3:1] == strap);
  assign ptr_inc   = ptr_q + ADDR_W'(1);
  assign word_addr = {hi, rx};

  // cnt counts clock rises within a byte: 0..7 data, 8 = ninth clock
  // pending, 9 = ninth clock seen. The fall that ends a Start sees cnt 0.
  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    rx_n     = rx;
    tx_n     = tx;
    hi_n     = hi;
    ptr_n    = ptr_q;
    oe_n     = oe;
    mack_n   = mack;
    mem_we   = 1'b0;
    ptr_step = 1'b0;
    if (stop_p) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (start_p) begin
      st_n  = ST_DEV;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (scl_rise && active) begin
      if (cnt < 4'd8) begin
        if (rx_state) begin
          rx_n = {rx[BYTE_W-2:0], sda_lvl};
        end
        cnt_n = cnt + 4'd1;
      end else if (cnt == 4'd8) begin
        cnt_n = 4'd9;
        if (st == ST_RD) begin
          mack_n = ~sda_lvl;
        end
      end
    end else if (scl_fall && active) begin
      if (cnt == 4'd8) begin
        unique case (st)
          ST_DEV: begin
            if (dev_hit) begin
              oe_n   = 1'b1;
              mack_n = 1'b1;
              st_n   = rx[0] ? ST_RD : ST_AHI;
            end else begin
              st_n = ST_SKIP;
            end
          end
          ST_AHI: begin
            hi_n = rx;
            oe_n = 1'b1;
            st_n = ST_ALO;
          end
          ST_ALO: begin
            ptr_n = ADDR_W'(word_addr);
            oe_n  = 1'b1;
            st_n  = ST_WR;
          end
          ST_WR: begin
            mem_we   = 1'b1;
            ptr_step = 1'b1;
            ptr_n    = ptr_inc;
            oe_n     = 1'b1;
          end
          default: begin
            oe_n = 1'b0;
          end
        endcase
      end else if (cnt == 4'd9) begin
        cnt_n = '0;
        oe_n  = 1'b0;
        if (st == ST_RD) begin
          if (mack) begin
            tx_n     = rdata;
            oe_n     = ~rdata[BYTE_W-1];
            ptr_n    = ptr_inc;
            ptr_step = 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end else if ((st == ST_RD) && (cnt != 4'd0)) begin
        tx_n = {tx[BYTE_W-2:0], 1'b0};
        oe_n = ~tx[BYTE_W-2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      rx    <= '0;
      tx    <= '0;
      hi    <= '0;
      ptr_q <= '0;
      oe    <= 1'b0;
      mack  <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      rx    <= rx_n;
      tx    <= tx_n;
      hi    <= hi_n;
      ptr_q <= ptr_n;
      oe    <= oe_n;
      mack  <= mack_n;
    end
  end

  assign sda_oe    = oe;
  assign mem_wdata = rx;
  assign ptr       = ptr_q;
  assign state     = st;

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned STORE_W     = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               lock_top
);

  logic              rst_s;
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;
  logic              mem_we, mem_commit, ptr_step;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;
  logic [ADDR_W-1:0] ptr;
  eep_state_e        state;

  eep_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_sn (rst_s)
  );

  eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk      (clk),
    .rst_n    (rst_s),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  eep_slave_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .sda_lvl   (sda_lvl),
    .strap     (strap_addr),
    .rdata     (mem_rdata),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .ptr       (ptr),
    .ptr_step  (ptr_step),
    .state     (state)
  );

  eep_store #(.ADDR_W(ADDR_W), .STORE_W(STORE_W), .DATA_W(BYTE_W)) u_store (
    .clk    (clk),
    .we     (mem_we),
    .lock   (lock_top),
    .addr   (ptr),
    .wdata  (mem_wdata),
    .rdata  (mem_rdata),
    .commit (mem_commit)
  );

endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              start_p,
  input logic              stop_p,
  input logic              sda_oe,
  input eep_state_e        state,
  input logic              mem_commit,
  input logic              lock_top,
  input logic [ADDR_W-1:0] ptr,
  input logic              ptr_step
);

  p_oe_steady_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(start_p) && !$past(stop_p)) |-> $stable(sda_oe));

  p_stop_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (!sda_oe && state == ST_IDLE));

  p_start_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && !stop_p) |=> (state == ST_DEV));

  p_quiet_when_unselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP || state == ST_IDLE) |-> !sda_oe);

  p_locked_quarter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_commit && lock_top) |-> !(&ptr[ADDR_W-1 -: 2]));

  // Pointer advance is one step modulo the space (R6, R9).
  p_ptr_step_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> (ptr == ADDR_W'($past(ptr) + ADDR_W'(1))));

endmodule

bind i2c_eeprom_slave eep_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .scl_lvl    (scl_lvl),
  .start_p    (start_p),
  .stop_p     (stop_p),
  .sda_oe     (sda_oe),
  .state      (state),
  .mem_commit (mem_commit),
  .lock_top   (lock_top),
  .ptr        (ptr),
  .ptr_step   (ptr_step)
);

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;

  localparam int CLK_P = 10;
  localparam int Q     = 6;
  localparam logic [2:0] DEV = 3'b101;

  logic clk, rst_n, scl_m, sda_m, lock;
  logic [2:0] strap;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [8192];

  i2c_eeprom_slave #(.ADDR_W(13), .STORE_W(13), .SYNC_STAGES(2)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .strap_addr (strap),
    .lock_top   (lock)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic read_bit(output bit s1, output bit s2);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    s1 = sda_line; wq();
    s2 = sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit s1, s2;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(s1, s2);
    ack = !s1;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v, output bit steady);
    bit s1, s2;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      read_bit(s1, s2);
      v[i] = s1;
      if (s1 != s2) steady = 1'b0;
    end
    send_bit(!mack);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'(a * 37 + k * 11 + 5);
  endfunction

  task automatic set_ptr(input logic [15:0] a);
    bit ack;
    start_c();
    send_byte({4'b1010, DEV, 1'b0}, ack);
    chk(ack, "R4 device write ack", ack, 1);
    send_byte(a[15:8], ack);
    chk(ack, "R5 high address ack", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R5 low address ack", ack, 1);
  endtask

  task automatic write_seq(input int a, input int n, input int k);
    bit ack;
    set_ptr(16'(a));
    for (int i = 0; i < n; i++) begin
      int aa;
      logic [7:0] v;
      aa = (a + i) & 32'h1FFF;
      v  = pat(aa, k);
      send_byte(v, ack);
      chk(ack, "R6 data ack", ack, 1);
      if (!(lock && aa >= 32'h1800)) model[aa] = v;
    end
    stop_c();
  endtask

  task automatic read_seq(input int a, input int n, input string req);
    bit ack, steady;
    logic [7:0] v;
    set_ptr(16'(a));
    start_c();
    send_byte({4'b1010, DEV, 1'b1}, ack);
    chk(ack, "R11 device read ack after repeated start", ack, 1);
    for (int i = 0; i < n; i++) begin
      int aa;
      aa = (a + i) & 32'h1FFF;
      recv_byte(i < n - 1, v, steady);
      chk(v === model[aa], req, v, model[aa]);
      chk(steady, "R3 data steady while clock high", steady, 1);
    end
    stop_c();
  endtask

  initial begin
    bit ack, steady, s1, s2;
    logic [7:0] v;
    scl_m = 1'b1; sda_m = 1'b1; strap = DEV; lock = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset leaves the line released
    chk(sda_oe == 1'b0, "R1 output enable after reset", sda_oe, 0);
    chk(sda_line == 1'b1, "R1 line level after reset", sda_line, 1);

    // R6 / R11: sequential write sweep then random read-back
    write_seq(32'h0100, 24, 1);
    read_seq(32'h0100, 24, "R9 sequential read data");

    // R4: every chip-address value, only the strapped one answers
    for (int s = 0; s < 8; s++) begin
      start_c();
      send_byte({4'b1010, 3'(s), 1'b0}, ack);
      chk(ack == (s == DEV), "R4 chip address match", ack, (s == DEV));
      if (s != DEV) begin
        send_byte(8'h00, ack);
        chk(!ack, "R4 unselected slave ignores bus", ack, 0);
      end
      stop_c();
    end
    start_c();
    send_byte({4'b1011, DEV, 1'b0}, ack);
    chk(!ack, "R4 wrong type code not acked", ack, 0);
    stop_c();

    // R5: upper three bits of high address byte ignored
    start_c();
    send_byte({4'b1010, DEV, 1'b0}, ack);
    send_byte(8'hE2, ack);
    chk(ack, "R5 masked high byte ack", ack, 1);
    send_byte(8'h34, ack);
    send_byte(8'h5A, ack);
    chk(ack, "R6 data ack", ack, 1);
    stop_c();
    model[13'h0234] = 8'h5A;
    read_seq(32'h0234, 1, "R5 masked address lands at 0234h");

    // R7 / R8: lock blocks only the top quarter, pointer still advances
    lock = 1'b0;
    write_seq(32'h17FE, 5, 2);
    lock = 1'b1;
    write_seq(32'h17FE, 4, 3);
    start_c();
    send_byte({4'b1010, DEV, 1'b1}, ack);
    chk(ack, "R11 current address read ack", ack, 1);
    recv_byte(1'b0, v, steady);
    chk(v === model[13'h1802], "R7 pointer advanced past blocked bytes", v, model[13'h1802]);
    stop_c();
    read_seq(32'h17FE, 5, "R8 read under lock");
    lock = 1'b0;
    write_seq(32'h1800, 2, 4);
    read_seq(32'h1800, 2, "R7 write allowed when unlocked");

    // R9: wrap from 1FFFh to 0000h on write and read
    write_seq(32'h1FFE, 4, 5);
    read_seq(32'h1FFE, 4, "R9 wrap at top of space");

    // R10: master not-acknowledge ends read, line stays released
    set_ptr(16'h0100);
    start_c();
    send_byte({4'b1010, DEV, 1'b1}, ack);
    recv_byte(1'b0, v, steady);
    chk(v === model[13'h0100], "R10 read byte before nack", v, model[13'h0100]);
    for (int i = 0; i < 9; i++) begin
      read_bit(s1, s2);
      chk(s1 && s2, "R10 line released after nack", s1, 1);
    end
    stop_c();

    // R2: Start partway through a data byte aborts it
    write_seq(32'h0300, 1, 6);
    set_ptr(16'h0300);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    start_c();
    send_byte({4'b1010, DEV, 1'b1}, ack);
    chk(ack, "R2 start mid byte restarts decoding", ack, 1);
    recv_byte(1'b0, v, steady);
    chk(v === model[13'h0300], "R2 partial byte not stored", v, model[13'h0300]);
    stop_c();
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule